// File: doc/BRIEF.md
# Dual-Channel Capture/Compare PWM Timer

A 16-bit up-counter shared by two capture/compare systems, A and B, each owning one pin. A system in capture mode treats its pin as an input: the pin is synchronised, an edge chosen by that system's trigger field copies the counter into the system's capture register, and a capture flag is raised. A capture that lands while the flag is still set also raises that system's overwrite flag.

A system in compare mode turns its pin into an output. Two waveform generators, one per pin, each watch both compare matches: match A when the counter equals compare value A, match B when it equals compare value B. A 2-bit mode picks hold-low, PWM (set on A, clear on B), toggle on A or toggle on B. A polarity bit inverts the result. While either system is in compare mode the counter restarts from zero after a match B, so compare value B sets the period.

Software reaches the block through a plain single-cycle register port: one address shared by write and read, and read data that follows the address combinationally. The count advances only on cycles where the count enable is high and the run bit is set. The block carries no streaming data, so it has no valid/ready handshake. Every register write completes in the cycle it is presented.

Top module: `cc_timer`

## Requirements
- R1: With run (CTRL bit 0) set, the counter rises by exactly one on each clock where `cnt_en` is high. With `cnt_en` low or run clear, it holds its value.
- R2: Writing CTRL with bit 1 set clears the counter and both waveform generator states at that clock edge. This clear overrides counting. Bit 1 is not stored.
- R3: With both systems in capture mode (CFG bits 1:0 = 0), the counter rolls over from 0xFFFF to 0. With either system in compare mode, a count step taken while the counter equals CMPB (address 3) loads 0 instead.
- R4: Trigger fields are CFG[3:2] for A and CFG[5:4] for B. The encoding is 0 = off, 1 = rising, 2 = falling, 3 = both edges. An edge that the field does not select captures nothing and sets no flag.
- R5: A selected edge on a capture-mode pin copies the counter into CAPA (address 4) or CAPB (address 5). It also sets the capture flag, FLAGS bit 0 for A and bit 1 for B. This happens on the third rising clock after the pin changes: two synchroniser stages, then the edge-detect register.
- R6: A capture on a system whose capture flag is already set also sets its overwrite flag, FLAGS bit 2 for A and bit 3 for B.
- R7: Writing FLAGS (address 6) with a 1 in a bit position clears that flag. A flag event in the same cycle wins over the clear.
- R8: `pin_oe` bit i equals CFG bit i: 1 = compare mode, pin is an output; 0 = capture mode.
- R9: Generator 0 drives `pin_out[0]` under mode CFG[7:6] and polarity CFG[10]. Generator 1 drives `pin_out[1]` under mode CFG[9:8] and polarity CFG[11]. Mode 0 gives a constant level equal to the polarity bit.
- R10: Mode 1 (PWM) sets the generator state one clock after a match A and clears it one clock after a match B. When both matches coincide, the clear wins. A match is a count step taken while the counter equals that compare value.
- R11: Mode 2 toggles the generator state on each match A. Mode 3 toggles it on each match B. Either generator may use either match.
- R12: `pin_out` is the generator state XOR its polarity bit.
- R13: `irq_cap[i]` and `irq_ovr[i]` mirror the capture and overwrite flags of system i (0 = A, 1 = B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-clock enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (write and read) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`: 0 CTRL, 1 CFG, 2 CMPA, 3 CMPB, 4 CAPA, 5 CAPB, 6 FLAGS, 7 COUNT |
| pin_in | input | 2 | Pin levels seen as capture triggers (bit 0 = A) |
| pin_out | output | 2 | Waveform generator outputs |
| pin_oe | output | 2 | Pin output enables |
| irq_cap | output | 2 | Capture interrupt per system |
| irq_ovr | output | 2 | Overwrite interrupt per system |

## Verification
The hardest case to reach is the counter's natural rollover at 0xFFFF. It only occurs with both systems in capture mode, after the full 65,536-step count. The bench presets the counter and lets it run with the enable held high. It polls the count through the read port each cycle until it reads 0xFFFF, then checks that the next cycle reads zero. Captures are taken with the counter stopped at a known value, so the expected capture does not depend on the synchroniser latency. The overwrite case is reached by sending a second selected edge before clearing the flag.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic [1:0] {TRG_OFF = 2'd0, TRG_RISE = 2'd1, TRG_FALL = 2'd2, TRG_BOTH = 2'd3} trig_e;
  typedef enum logic [1:0] {WAV_LOW = 2'd0, WAV_PWM = 2'd1, WAV_TGLA = 2'd2, WAV_TGLB = 2'd3} wave_e;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_CFG   = 3'd1;
  localparam logic [2:0] A_CMPA  = 3'd2;
  localparam logic [2:0] A_CMPB  = 3'd3;
  localparam logic [2:0] A_CAPA  = 3'd4;
  localparam logic [2:0] A_CAPB  = 3'd5;
  localparam logic [2:0] A_FLAGS = 3'd6;
  localparam logic [2:0] A_COUNT = 3'd7;
endpackage

// File: rtl/cc_timer_counter.sv
module cc_timer_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  input  logic         tick,
  input  logic         wrap_en,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] count,
  output logic         hit_a,
  output logic         hit_b
);
  logic step;

  assign step  = run & tick;
  assign hit_a = step & (count == cmp_a);
  assign hit_b = step & (count == cmp_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clear)            count <= '0;
    else if (hit_b && wrap_en) count <= '0;
    else if (step)             count <= count + 1'b1;
  end
endmodule

// File: rtl/cc_timer_capture.sv
module cc_timer_capture
  import cc_timer_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  logic         active,
  input  trig_e        trig,
  input  logic [W-1:0] count,
  input  logic         clr_cap,
  input  logic         clr_ovr,
  output logic [W-1:0] cap_q,
  output logic         cap_flag,
  output logic         ovr_flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall, fire;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

  always_comb begin
    unique case (trig)
      TRG_RISE: fire = rise;
      TRG_FALL: fire = fall;
      TRG_BOTH: fire = rise | fall;
      default:  fire = 1'b0;
    endcase
    fire = fire & active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= '0;
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (fire) cap_q <= count;
      if (fire)         cap_flag <= 1'b1;
      else if (clr_cap) cap_flag <= 1'b0;
      if (fire && cap_flag) ovr_flag <= 1'b1;
      else if (clr_ovr)     ovr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cc_timer_wave.sv
module cc_timer_wave
  import cc_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  wave_e mode,
  input  logic  invert,
  input  logic  hit_a,
  input  logic  hit_b,
  output logic  wave_out
);
  logic state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (mode)
      WAV_PWM: begin
        if (hit_b)      state_d = 1'b0;
        else if (hit_a) state_d = 1'b1;
      end
      WAV_TGLA: if (hit_a) state_d = ~state_q;
      WAV_TGLB: if (hit_b) state_d = ~state_q;
      default:  state_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= 1'b0;
    else if (clear) state_q <= 1'b0;
    else            state_q <= state_d;
  end

  assign wave_out = ((mode == WAV_LOW) ? 1'b0 : state_q) ^ invert;
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         bus_wr,
  input  logic [2:0]   bus_addr,
  input  logic [15:0]  bus_wdata,
  output logic [15:0]  bus_rdata,
  input  logic [1:0]   pin_in,
  output logic [1:0]   pin_out,
  output logic [1:0]   pin_oe,
  output logic [1:0]   irq_cap,
  output logic [1:0]   irq_ovr
);
  localparam int NSYS = 2;

  logic          run_q;
  logic [11:0]   cfg_q;
  logic [W-1:0]  cmpa_q, cmpb_q;
  logic          clear;
  logic          wr_flags;
  logic [W-1:0]  cnt_q;
  logic          hit_a, hit_b;
  logic [NSYS-1:0] cmp_mode;
  logic [NSYS-1:0] cap_if, ovr_if;
  logic [W-1:0]  cap_val [NSYS];
  trig_e         trig_sel [NSYS];
  wave_e         wave_sel [NSYS];
  logic [NSYS-1:0] wave_inv;

  assign clear    = bus_wr && (bus_addr == A_CTRL) && bus_wdata[1];
  assign wr_flags = bus_wr && (bus_addr == A_FLAGS);
  assign cmp_mode = cfg_q[1:0];
  assign trig_sel[0] = trig_e'(cfg_q[3:2]);
  assign trig_sel[1] = trig_e'(cfg_q[5:4]);
  assign wave_sel[0] = wave_e'(cfg_q[7:6]);
  assign wave_sel[1] = wave_e'(cfg_q[9:8]);
  assign wave_inv    = cfg_q[11:10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cfg_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_CTRL: run_q  <= bus_wdata[0];
        A_CFG:  cfg_q  <= bus_wdata[11:0];
        A_CMPA: cmpa_q <= bus_wdata[W-1:0];
        A_CMPB: cmpb_q <= bus_wdata[W-1:0];
        default: ;
      endcase
    end
  end

  cc_timer_counter #(.W(W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .run     (run_q),
    .tick    (cnt_en),
    .wrap_en (|cmp_mode),
    .cmp_a   (cmpa_q),
    .cmp_b   (cmpb_q),
    .count   (cnt_q),
    .hit_a   (hit_a),
    .hit_b   (hit_b)
  );

  generate
    for (genvar i = 0; i < NSYS; i++) begin : g_sys
      cc_timer_capture #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (pin_in[i]),
        .active   (~cmp_mode[i]),
        .trig     (trig_sel[i]),
        .count    (cnt_q),
        .clr_cap  (wr_flags && bus_wdata[i]),
        .clr_ovr  (wr_flags && bus_wdata[i+2]),
        .cap_q    (cap_val[i]),
        .cap_flag (cap_if[i]),
        .ovr_flag (ovr_if[i])
      );

      cc_timer_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .mode     (wave_sel[i]),
        .invert   (wave_inv[i]),
        .hit_a    (hit_a),
        .hit_b    (hit_b),
        .wave_out (pin_out[i])
      );
    end
  endgenerate

  assign pin_oe  = cmp_mode;
  assign irq_cap = cap_if;
  assign irq_ovr = ovr_if;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata = {15'd0, run_q};
      A_CFG:   bus_rdata = {4'd0, cfg_q};
      A_CMPA:  bus_rdata = 16'(cmpa_q);
      A_CMPB:  bus_rdata = 16'(cmpb_q);
      A_CAPA:  bus_rdata = 16'(cap_val[0]);
      A_CAPB:  bus_rdata = 16'(cap_val[1]);
      A_FLAGS: bus_rdata = {12'd0, ovr_if, cap_if};
      default: bus_rdata = 16'(cnt_q);
    endcase
  end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         run_q,
  input logic         clear,
  input logic         bus_wr,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] cmpb_q,
  input logic [1:0]   cmp_mode,
  input logic         hit_b,
  input logic [11:0]  cfg_q,
  input logic [1:0]   pin_out,
  input logic [1:0]   cap_if,
  input logic [1:0]   ovr_if
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(run_q && cnt_en)) |=> $stable(cnt_q));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && run_q && cnt_en && (|cmp_mode) && (cnt_q == cmpb_q)) |=> (cnt_q == '0));

  assert_ovr_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_if[0]) |-> $past(cap_if[0]));

  assert_ovr_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_if[1]) |-> $past(cap_if[1]));

  assert_low_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[7:6] == 2'd0) |-> (pin_out[0] == cfg_q[10]));

  assert_pwm_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[7:6] == 2'd1 && hit_b && !bus_wr) |=> (pin_out[0] == cfg_q[10]));
endmodule

bind cc_timer cc_timer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .run_q    (run_q),
  .clear    (clear),
  .bus_wr   (bus_wr),
  .cnt_q    (cnt_q),
  .cmpb_q   (cmpb_q),
  .cmp_mode (cmp_mode),
  .hit_b    (hit_b),
  .cfg_q    (cfg_q),
  .pin_out  (pin_out),
  .cap_if   (cap_if),
  .ovr_if   (ovr_if)
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [1:0]  pin_in = 2'b00;
  logic [1:0]  pin_out, pin_oe, irq_cap, irq_ovr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cc_timer u_cc_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_cap(irq_cap), .irq_ovr(irq_ovr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(3'd7, v); check("R1 reset count", v, 16'h0000);
    rd(3'd6, v); check("R13 reset flags", v, 16'h0000);
    check("R8 reset oe", {14'd0, pin_oe}, 16'h0000);
    check("R9 reset pin_out", {14'd0, pin_out}, 16'h0000);
  endtask

  task automatic t_count;
    logic [15:0] a, b;
    wr(3'd0, 16'h0003);
    @(negedge clk);
    rd(3'd7, a);
    cnt_en = 1'b1;
    repeat (5) @(negedge clk);
    cnt_en = 1'b0;
    rd(3'd7, b); check("R1 advance by five", b, a + 16'd5);
    repeat (4) @(negedge clk);
    rd(3'd7, b); check("R1 hold without enable", b, a + 16'd5);
    wr(3'd0, 16'h0000);
    cnt_en = 1'b1;
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    rd(3'd7, b); check("R1 hold with run clear", b, a + 16'd5);
    wr(3'd0, 16'h0002);
    rd(3'd7, b); check("R2 preset clears", b, 16'h0000);
    rd(3'd0, b); check("R2 preset bit not stored", b, 16'h0000);
  endtask

  task automatic t_capture;
    logic [15:0] c, v;
    wr(3'd1, 16'h0004 | 16'h0030);
    wr(3'd0, 16'h0003);
    cnt_en = 1'b1;
    repeat (7) @(negedge clk);
    cnt_en = 1'b0;
    wr(3'd0, 16'h0000);
    rd(3'd7, c);
    check("R8 capture mode oe", {14'd0, pin_oe}, 16'h0000);
    pin_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(3'd6, v); check("R5 no flag before third edge", v, 16'h0000);
    @(negedge clk);
    rd(3'd6, v); check("R5 flag on third edge", v, 16'h0001);
    rd(3'd4, v); check("R5 CAPA value", v, c);
    check("R13 irq_cap A", {14'd0, irq_cap}, 16'h0001);
    pin_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd6, v); check("R4 falling ignored by rising trigger", v, 16'h0001);
    pin_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd6, v); check("R6 overwrite A", v, 16'h0005);
    check("R13 irq_ovr A", {14'd0, irq_ovr}, 16'h0001);
    wr(3'd6, 16'h0001);
    rd(3'd6, v); check("R7 clear capture only", v, 16'h0004);
    wr(3'd6, 16'h000F);
    rd(3'd6, v); check("R7 clear all", v, 16'h0000);
    wr(3'd0, 16'h0001);
    cnt_en = 1'b1;
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    wr(3'd0, 16'h0000);
    rd(3'd7, c);
    pin_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    pin_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd6, v); check("R4 both edges on B two captures", v, 16'h000A);
    rd(3'd5, v); check("R5 CAPB value", v, c);
    wr(3'd6, 16'h000F);
    wr(3'd1, 16'h0000);
    pin_in = 2'b11;
    repeat (4) @(negedge clk);
    pin_in = 2'b00;
    repeat (4) @(negedge clk);
    rd(3'd6, v); check("R4 disabled trigger ignored", v, 16'h0000);
  endtask

  task automatic t_pwm;
    logic [15:0] c;
    logic exp;
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd9);
    wr(3'd1, 16'h0003 | (16'd1 << 6) | (16'd0 << 8) | (16'd1 << 11));
    check("R8 compare mode oe", {14'd0, pin_oe}, 16'h0003);
    cnt_en = 1'b1;
    wr(3'd0, 16'h0003);
    for (int k = 0; k < 24; k++) begin
      rd(3'd7, c);
      exp = (c >= 16'd4) && (c <= 16'd9);
      check("R10 PWM level", {15'd0, pin_out[0]}, {15'd0, exp});
      check("R12 inverted mode 0", {15'd0, pin_out[1]}, 16'h0001);
      if (c > 16'd9) check("R3 wrap at CMPB", c, 16'd9);
      @(negedge clk);
    end
    cnt_en = 1'b0;
  endtask

  task automatic t_toggle(input logic [1:0] md, input int exp_n, input string req);
    int n = 0;
    logic last;
    wr(3'd1, 16'h0003 | (16'(md) << 8));
    cnt_en = 1'b1;
    wr(3'd0, 16'h0003);
    #1 last = pin_out[1];
    for (int k = 0; k < 28; k++) begin
      @(negedge clk);
      #1 if (pin_out[1] !== last) n++;
      last = pin_out[1];
    end
    cnt_en = 1'b0;
    check(req, 16'(n), 16'(exp_n));
  endtask

  task automatic t_rollover;
    logic [15:0] v;
    int guard = 0;
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0003);
    cnt_en = 1'b1;
    rd(3'd7, v);
    while (v != 16'hFFFF && guard < 70000) begin
      @(negedge clk);
      rd(3'd7, v);
      guard++;
    end
    check("R3 reaches 0xFFFF", v, 16'hFFFF);
    @(negedge clk);
    rd(3'd7, v);
    check("R3 rollover to zero", v, 16'h0000);
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_capture();
    t_pwm();
    t_toggle(2'd2, 3, "R11 toggle on match A");
    t_toggle(2'd3, 2, "R11 toggle on match B");
    t_rollover();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule